// File: doc/BRIEF.md
# SCL timing generator

This block produces the clock waveform of an I2C controller from a faster source clock. A prescaler divides the source clock into base ticks. Three counts, captured from one packed configuration word, set how many base ticks SCL spends released high, how many it spends driven low, and how long a full bit period lasts. If the period count is larger than high plus low, the surplus ticks are spent holding SCL low right after it falls, before the low phase proper is counted.

The command sequencer raises `run` to request bit periods and receives two one-cycle strobes. The first marks the middle of each low phase, where SDA may change. The second marks the middle of each high phase, where SDA may be sampled. SCL is open drain. Once the block releases it, the high-phase count waits until the line is actually seen high, so a target that holds SCL low stretches the period. Divider and counts are captured only while the generator is idle, so the settings never change inside a bit period.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset SCL is released (`sclDriveLow` = 0) and both strobes are low.
- R2: The low count sits in `cfgWord[19:10]`. Each low phase drives SCL low for low count × divider source cycles.
- R3: The high count sits in `cfgWord[29:20]`. With no stretching, SCL stays released for high count × divider source cycles.
- R4: The period count sits in `cfgWord[9:0]`. When it exceeds high + low, SCL is held low for (period − high − low) × divider extra cycles right after it falls, so successive falls are max(period, high + low) × divider cycles apart.
- R5: The effective divider is `clkDiv`, with 0 treated as 1.
- R6: A high or low count of 0 behaves as 1.
- R7: While SCL is released but still read low on `sclIn`, the high phase does not advance. High time is counted from the first cycle SCL is read high.
- R8: `sdaChangeStb` pulses for one cycle max(1, floor(low/2)) × divider cycles after each low phase starts. The low phase starts after any hold time.
- R9: `sdaSampleStb` pulses for one cycle max(1, floor(high/2)) × divider cycles after SCL is first read high in a high phase.
- R10: While `clkEn` is 0 no base ticks occur. An idle generator does not start, a running one keeps its SCL level, and no strobes fire.
- R11: `clkDiv` and `cfgWord` are captured only while idle. Changes made during a bit period take effect only from the next start.
- R12: An idle generator with `run` = 1 and `clkEn` = 1 drives SCL low from the next cycle. At the end of each bit period (after high or hold) it goes on with another bit period if `run` = 1, and otherwise goes idle with SCL released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEn | input | 1 | Serial clock enable; no ticks while 0 |
| clkDiv | input | DIV_W (8) | Source clocks per base tick (0 acts as 1) |
| cfgWord | input | 3×CNT_W (30) | Packed high / low / period counts |
| run | input | 1 | Request for bit periods |
| sclIn | input | 1 | Observed level of the SCL line |
| sclDriveLow | output | 1 | 1 = pull SCL low, 0 = release |
| sdaChangeStb | output | 1 | One-cycle mid-low strobe |
| sdaSampleStb | output | 1 | One-cycle mid-high strobe |

## Verification
The SDA-change strobe and the end of the low phase fall in the same cycle when the low count is 1 (or 0). In that case the strobe is first seen in the first released cycle, and not while SCL is still low. Vectors with low counts of 0 and 1 provoke this. The bench compares every cycle of the SCL level and of both strobes against a trace it computes from the counts, so a strobe that is lost, repeated or moved by one cycle at that boundary is reported. The same trace comparison covers the case where a hold phase ending and a new low phase starting share an edge in back-to-back bit periods.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2,
    PH_HOLD = 2'd3
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   load;     // capture divider and counts
    logic   divHold;  // keep the prescaler at zero
    logic   cntClr;   // restart the phase counter
    phase_e sel;      // which limit the datapath compares against
  } ctrlStb_t;

  // conditions from datapath to control
  typedef struct packed {
    logic lastTick;
    logic midTick;
    logic holdZero;
  } dpStat_t;

endpackage

// File: rtl/scl_tick_div.sv
module scl_tick_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [DIV_W-1:0] divIn,
  input  logic             enable,
  input  logic             hold,
  output logic             tick
);
  localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     divReg <= '0;
    else if (load) divReg <= divIn;
  end

  // a divider of zero behaves as one
  assign divLast = (divReg == '0) ? '0 : divReg - DIV_ONE;
  assign tick    = enable && !hold && (divCnt == divLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        divCnt <= '0;
    else if (!enable || hold || tick) divCnt <= '0;
    else                              divCnt <= divCnt + DIV_ONE;
  end

  // R5
  div_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !hold) |-> (divCnt <= divLast));

endmodule

// File: rtl/scl_timing_dp.sv
module scl_timing_dp
  import scl_timing_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStb_t           ctrl,
  input  logic [3*CNT_W-1:0] cfgWord,
  input  logic               tick,
  output dpStat_t            stat
);
  localparam int                CFG_W   = 3 * CNT_W;
  localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);

  logic [CFG_W-1:0] cfgReg;
  logic [CNT_W-1:0] cycReg, lowReg, highReg;
  logic [CNT_W-1:0] lowEff, highEff, lowHalf, highHalf;
  logic [CNT_W:0]   sumHL, cycExt, diff;
  logic [CNT_W-1:0] holdCnt;
  logic [CNT_W-1:0] limit, midM1;
  logic [CNT_W-1:0] phaseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cfgReg <= '0;
    else if (ctrl.load) cfgReg <= cfgWord;
  end

  assign cycReg  = cfgReg[CNT_W-1:0];
  assign lowReg  = cfgReg[2*CNT_W-1:CNT_W];
  assign highReg = cfgReg[3*CNT_W-1:2*CNT_W];

  // zero counts act as one
  assign lowEff  = (lowReg  == '0) ? CNT_ONE : lowReg;
  assign highEff = (highReg == '0) ? CNT_ONE : highReg;
  assign lowHalf  = lowEff  >> 1;
  assign highHalf = highEff >> 1;

  // surplus period ticks become hold time after the falling edge
  assign sumHL   = {1'b0, lowEff} + {1'b0, highEff};
  assign cycExt  = {1'b0, cycReg};
  assign diff    = cycExt - sumHL;
  assign holdCnt = (cycExt > sumHL) ? diff[CNT_W-1:0] : '0;

  always_comb begin
    case (ctrl.sel)
      PH_LOW: begin
        limit = lowEff;
        midM1 = (lowHalf == '0) ? '0 : lowHalf - CNT_ONE;
      end
      PH_HIGH: begin
        limit = highEff;
        midM1 = (highHalf == '0) ? '0 : highHalf - CNT_ONE;
      end
      PH_HOLD: begin
        limit = holdCnt;
        midM1 = '0;
      end
      default: begin
        limit = CNT_ONE;
        midM1 = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            phaseCnt <= '0;
    else if (ctrl.cntClr) phaseCnt <= '0;
    else if (tick)        phaseCnt <= phaseCnt + CNT_ONE;
  end

  assign stat.lastTick = tick && (phaseCnt == limit - CNT_ONE);
  assign stat.midTick  = tick && (phaseCnt == midM1);
  assign stat.holdZero = (holdCnt == '0);

  // R2
  phase_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.sel != PH_IDLE) |-> (phaseCnt < limit));

  // R11
  cfg_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> $stable(cfgReg));

endmodule

// File: rtl/scl_timing_ctrl.sv
module scl_timing_ctrl
  import scl_timing_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     run,
  input  logic     clkEn,
  input  logic     sclIn,
  input  dpStat_t  stat,
  output ctrlStb_t ctrl,
  output logic     sclDriveLow,
  output logic     sdaChangeStb,
  output logic     sdaSampleStb
);
  phase_e state, nxt;

  always_comb begin
    ctrl     = '0;
    ctrl.sel = state;
    nxt      = state;
    case (state)
      PH_IDLE: begin
        ctrl.load    = 1'b1;
        ctrl.divHold = 1'b1;
        ctrl.cntClr  = 1'b1;
        if (run && clkEn) nxt = PH_LOW;
      end
      PH_LOW: begin
        if (stat.lastTick) begin
          ctrl.cntClr = 1'b1;
          nxt         = PH_HIGH;
        end
      end
      PH_HIGH: begin
        // the count waits until the line is actually seen high
        ctrl.divHold = !sclIn;
        if (stat.lastTick) begin
          ctrl.cntClr = 1'b1;
          if (!stat.holdZero) nxt = PH_HOLD;
          else                nxt = run ? PH_LOW : PH_IDLE;
        end
      end
      PH_HOLD: begin
        if (stat.lastTick) begin
          ctrl.cntClr = 1'b1;
          nxt         = run ? PH_LOW : PH_IDLE;
        end
      end
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= PH_IDLE;
      sclDriveLow  <= 1'b0;
      sdaChangeStb <= 1'b0;
      sdaSampleStb <= 1'b0;
    end else begin
      state        <= nxt;
      sclDriveLow  <= (nxt == PH_LOW) || (nxt == PH_HOLD);
      sdaChangeStb <= (state == PH_LOW)  && stat.midTick;
      sdaSampleStb <= (state == PH_HIGH) && stat.midTick;
    end
  end

  // R10
  freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> $stable(state));

  // R12
  start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_IDLE && run && clkEn) |=> sclDriveLow);

  // R7
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_HIGH && !sclIn) |=> (state == PH_HIGH));

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sdaChangeStb && sdaSampleStb));

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clkEn,
  input  logic [DIV_W-1:0]   clkDiv,
  input  logic [3*CNT_W-1:0] cfgWord,
  input  logic               run,
  input  logic               sclIn,
  output logic               sclDriveLow,
  output logic               sdaChangeStb,
  output logic               sdaSampleStb
);
  ctrlStb_t ctrlS;
  dpStat_t  statS;
  logic     tick;

  scl_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rstN   (rstN),
    .load   (ctrlS.load),
    .divIn  (clkDiv),
    .enable (clkEn),
    .hold   (ctrlS.divHold),
    .tick   (tick)
  );

  scl_timing_dp #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrlS),
    .cfgWord (cfgWord),
    .tick    (tick),
    .stat    (statS)
  );

  scl_timing_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .run          (run),
    .clkEn        (clkEn),
    .sclIn        (sclIn),
    .stat         (statS),
    .ctrl         (ctrlS),
    .sclDriveLow  (sclDriveLow),
    .sdaChangeStb (sdaChangeStb),
    .sdaSampleStb (sdaSampleStb)
  );

endmodule

// File: tb/scl_timing_gen_tb.sv
`timescale 1ns/1ps
module scl_timing_gen_tb;
  localparam int DIV_W = 8;
  localparam int CNT_W = 10;
  localparam int NV    = 10;

  // {div, high, low, period, bits, stretch cycles}
  localparam logic [47:0] VECS [NV] = '{
    {8'd7, 10'd10, 10'd12, 10'd26, 4'd1, 6'd0},
    {8'd2, 10'd5,  10'd11, 10'd22, 4'd2, 6'd0},
    {8'd1, 10'd2,  10'd8,  10'd18, 4'd1, 6'd0},
    {8'd8, 10'd14, 10'd18, 10'd38, 4'd1, 6'd0},
    {8'd4, 10'd3,  10'd9,  10'd19, 4'd2, 6'd0},
    {8'd2, 10'd3,  10'd5,  10'd15, 4'd1, 6'd0},
    {8'd0, 10'd0,  10'd0,  10'd0,  4'd3, 6'd0},
    {8'd3, 10'd4,  10'd1,  10'd3,  4'd2, 6'd0},
    {8'd2, 10'd4,  10'd4,  10'd8,  4'd2, 6'd5},
    {8'd1, 10'd5,  10'd7,  10'd12, 4'd2, 6'd0}
  };

  logic clk = 1'b0, rstN = 1'b0, clkEn = 1'b0, run = 1'b0, stretch = 1'b0;
  logic [DIV_W-1:0]   clkDiv  = '0;
  logic [3*CNT_W-1:0] cfgWord = '0;
  logic sclDriveLow, sdaChangeStb, sdaSampleStb, sclIn;
  int errors = 0, checks = 0, cycles = 0;

  assign sclIn = !sclDriveLow && !stretch;

  always #2.5 clk = ~clk;

  scl_timing_gen #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .clkDiv(clkDiv), .cfgWord(cfgWord),
    .run(run), .sclIn(sclIn), .sclDriveLow(sclDriveLow),
    .sdaChangeStb(sdaChangeStb), .sdaSampleStb(sdaSampleStb)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual cycles=%0d expected below 150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [3*CNT_W-1:0] packCfg(input int hi, input int lo, input int cyc);
    return {CNT_W'(hi), CNT_W'(lo), CNT_W'(cyc)};
  endfunction

  // Start a run and compare every cycle against a trace built from the counts.
  task automatic runTrace(input int div, input int hi, input int lo, input int cyc,
                          input int nBits, input int stall, input bit chg,
                          input int nDiv, input int nHi, input int nLo, input int nCyc,
                          input string tag);
    int dE = (div == 0) ? 1 : div;
    int hE = (hi == 0) ? 1 : hi;
    int lE = (lo == 0) ? 1 : lo;
    int h  = (cyc > hE + lE) ? cyc - hE - lE : 0;
    int L  = lE * dE;
    int H  = hE * dE;
    int P  = L + H + h * dE;
    int cm = (lE / 2 == 0) ? 1 : lE / 2;
    int sm = (hE / 2 == 0) ? 1 : hE / 2;
    int N  = nBits * P + stall + 12;
    int dropAt = (nBits - 1) * P + ((nBits > 1) ? stall : 0) + 1;
    int badL = 0, badC = 0, badS = 0;
    int tL = -1, tC = -1, tS = -1;
    int aL = 0, aC = 0, aS = 0;
    @(negedge clk);
    clkDiv  = DIV_W'(div);
    cfgWord = packCfg(hi, lo, cyc);
    stretch = (stall > 0);
    run     = 1'b1;
    @(negedge clk);
    for (int t = 0; t < N; t++) begin
      int  t2    = (t >= L + stall) ? t - stall : t;
      bit  inWin = (stall > 0) && (t >= L) && (t < L + stall);
      bit  eL    = !inWin && (t2 < nBits * P) && (((t2 % P) < L) || ((t2 % P) >= L + H));
      bit  eC    = 1'b0;
      bit  eS    = 1'b0;
      for (int b = 0; b < nBits; b++) begin
        if (t == b * P + cm * dE + ((b > 0) ? stall : 0)) eC = 1'b1;
        if (t == b * P + L + sm * dE + stall)             eS = 1'b1;
      end
      if (sclDriveLow !== eL)  begin badL++; if (tL < 0) begin tL = t; aL = int'(sclDriveLow); end end
      if (sdaChangeStb !== eC) begin badC++; if (tC < 0) begin tC = t; aC = int'(sdaChangeStb); end end
      if (sdaSampleStb !== eS) begin badS++; if (tS < 0) begin tS = t; aS = int'(sdaSampleStb); end end
      if (chg && t == 1) begin
        clkDiv  = DIV_W'(nDiv);
        cfgWord = packCfg(nHi, nLo, nCyc);
      end
      if (t == dropAt) run = 1'b0;
      if (stall > 0 && t == L + stall) stretch = 1'b0;
      @(negedge clk);
    end
    check(badL == 0, $sformatf("%s R2/R3/R4/R12 scl level at t=%0d", tag, tL), aL, 1 - aL);
    check(badC == 0, $sformatf("%s R8 change strobe at t=%0d", tag, tC), aC, 1 - aC);
    check(badS == 0, $sformatf("%s R9 sample strobe at t=%0d", tag, tS), aS, 1 - aS);
  endtask

  initial begin
    int bad;
    int nChg;
    int nSmp;
    logic [47:0] v;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(sclDriveLow == 1'b0, "R1 scl released in reset", int'(sclDriveLow), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(sclDriveLow == 1'b0,  "R1 scl released after reset", int'(sclDriveLow), 0);
    check(sdaChangeStb == 1'b0, "R1 change strobe low", int'(sdaChangeStb), 0);
    check(sdaSampleStb == 1'b0, "R1 sample strobe low", int'(sdaSampleStb), 0);

    clkEn = 1'b1;
    // table of vectors: R2 R3 R4 R5 R6 R7 R8 R9 R12
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      runTrace(int'(v[47:40]), int'(v[39:30]), int'(v[29:20]), int'(v[19:10]),
               int'(v[9:6]), int'(v[5:0]), 1'b0, 0, 0, 0, 0, $sformatf("vec%0d", i));
    end

    // R11: settings changed during a bit period do not disturb it
    runTrace(1, 6, 6, 12, 1, 0, 1'b1, 2, 3, 3, 10, "R11 mid-run change");
    runTrace(2, 3, 3, 10, 1, 0, 1'b0, 0, 0, 0, 0, "R11 next start");

    // R10: disabled clock, idle generator must not start
    clkEn   = 1'b0;
    clkDiv  = DIV_W'(1);
    cfgWord = packCfg(8, 8, 16);
    run     = 1'b1;
    bad     = 0;
    repeat (30) begin
      @(negedge clk);
      if (sclDriveLow) bad++;
    end
    check(bad == 0, "R10 no start while disabled", bad, 0);
    run   = 1'b0;
    clkEn = 1'b1;
    repeat (4) @(negedge clk);

    // R10: freeze inside a low phase
    run = 1'b1;
    @(negedge clk);
    @(negedge clk);
    clkEn = 1'b0;
    run   = 1'b0;
    bad   = 0;
    nChg  = 0;
    repeat (40) begin
      @(negedge clk);
      if (!sclDriveLow) bad++;
      if (sdaChangeStb || sdaSampleStb) nChg++;
    end
    check(bad == 0,  "R10 scl held low while frozen", bad, 0);
    check(nChg == 0, "R10 no strobes while frozen", nChg, 0);
    clkEn = 1'b1;
    nChg  = 0;
    nSmp  = 0;
    repeat (60) begin
      @(negedge clk);
      if (sdaChangeStb) nChg++;
      if (sdaSampleStb) nSmp++;
    end
    check(sclDriveLow == 1'b0, "R10 R12 released after resume", int'(sclDriveLow), 0);
    check(nChg == 1, "R8 one change strobe after resume", nChg, 1);
    check(nSmp == 1, "R9 one sample strobe after resume", nSmp, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule